// File: doc/BRIEF.md
# Dual-Mode PLL Lock Qualifier

This block turns a raw "inside the lock window" flag from a clock-synthesis loop into a registered lock indication. It runs on a free-running system clock. The phase detector supplies a one-clock strobe for each of its comparison cycles. The flag and the strobe arrive already synchronized to the system clock. The block has two qualification policies, and a mode input selects between them.

In phase-tracking mode the indication follows the raw flag without delay. A reference-activity watchdog gates it: the watchdog counts system clocks between detector strobes and withdraws the indication when the reference goes quiet for too long. In frequency-tracking mode the indication rises only after the raw flag has held across a programmed number of consecutive detector strobes. This mode does not consult the watchdog, so the indication can stay high after the reference stops, because no further detector cycles are judged. In both modes a lost window drops the indication at the next clock edge. A change to the mode or to the count setting restarts qualification from zero.

Top module: `pll_lock_qualifier`

## Requirements
- R1: With `mode_freq`=0 (phase tracking), `lock_o` is 1 at the clock edge after a cycle in which `in_window`=1 and the reference is active, with no qualification delay.
- R2: With `mode_freq`=1 (frequency tracking), `lock_o` rises at the edge that samples the Nth strobe of an unbroken run with `in_window`=1, where N = `qual_cnt`+1. Clocks with `in_window`=1 but no strobe neither advance nor break the run.
- R3: The required run length N is clamped to at least 16, so the usable range is 16 to 256. `qual_cnt` values of 0 to 15 all require 16 strobes, and 255 requires 256.
- R4: In either mode, a cycle with `in_window`=0 drives `lock_o` to 0 at the next edge and discards any partial run, even if a strobe arrives in that same cycle.
- R5: With `mode_freq`=0, once more than T consecutive clocks pass without a strobe, `lock_o` falls at the next edge. T is `ref_timeout`, clamped to at least 2. A strobe in the cycle that would otherwise exceed T keeps the reference active.
- R6: With `mode_freq`=1, the absence of strobes has no effect: a held `lock_o` stays 1 while `in_window` stays 1 and the settings are unchanged.
- R7: A synchronous reset (`rst_n`=0 at an edge) drives `lock_o` to 0 and clears the run and the watchdog.
- R8: Any change of `mode_freq` or `qual_cnt` from one cycle to the next drives `lock_o` to 0 at the next edge and restarts the run from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pd_strobe | input | 1 | One-clock pulse per phase-detector cycle |
| in_window | input | 1 | Raw lock-window flag from the detector |
| mode_freq | input | 1 | 0 = phase tracking, 1 = frequency tracking |
| qual_cnt | input | 8 | Run length minus one for frequency tracking |
| ref_timeout | input | 16 | Strobe-free clocks tolerated in phase tracking |
| lock_o | output | 1 | Registered lock indication |

## Verification
Two pairs of events can land in the same cycle. The first pair is a watchdog expiry and the arrival of a new strobe. The bench provokes it by letting exactly `ref_timeout` quiet clocks pass and then placing the strobe on the clock that would have exceeded the limit; the lock must stay high through that edge. The second pair is a strobe and a window loss in frequency mode. There the strobe must not count: the following run needs the full N strobes again before the lock rises.

// File: rtl/pll_lock_pkg.sv
`timescale 1ns/1ps
package pll_lock_pkg;

   typedef enum logic {
      LK_PHASE = 1'b0,
      LK_FREQ  = 1'b1
   } lock_mode_e;

endpackage

// File: rtl/lock_ref_watchdog.sv
`timescale 1ns/1ps
module lock_ref_watchdog #(
   parameter int TMO_W   = 16,
   parameter int MIN_TMO = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strobe,
   input  logic [TMO_W-1:0] tmo_in,
   output logic             ref_ok
);
   localparam logic [TMO_W-1:0] TMO_FLOOR = TMO_W'(MIN_TMO);
   localparam logic [TMO_W-1:0] GAP_MAX   = '1;

   logic [TMO_W-1:0] gap_q;
   logic [TMO_W-1:0] tmo_eff;

   assign tmo_eff = (tmo_in < TMO_FLOOR) ? TMO_FLOOR : tmo_in;
   // A strobe this cycle always counts as activity.
   assign ref_ok  = strobe || (gap_q < tmo_eff);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_q <= '0;
      end else if (strobe) begin
         gap_q <= '0;
      end else if (gap_q != GAP_MAX) begin
         gap_q <= gap_q + TMO_W'(1);
      end
   end
endmodule

// File: rtl/lock_run_counter.sv
`timescale 1ns/1ps
module lock_run_counter #(
   parameter int QUAL_W   = 8,
   parameter int MIN_QUAL = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              clear,
   input  logic              window,
   input  logic              strobe,
   input  logic [QUAL_W-1:0] qual_cnt,
   output logic              qualified
);
   localparam int RUN_W = QUAL_W + 1;
   localparam logic [RUN_W-1:0] RUN_FLOOR = RUN_W'(MIN_QUAL);

   logic [RUN_W-1:0] run_q;
   logic [RUN_W-1:0] run_d;
   logic [RUN_W-1:0] need_raw;
   logic [RUN_W-1:0] need;

   assign need_raw = {1'b0, qual_cnt} + RUN_W'(1);
   assign need     = (need_raw < RUN_FLOOR) ? RUN_FLOOR : need_raw;

   always_comb begin
      if (!enable || clear || !window) begin
         run_d = '0;
      end else if (strobe && (run_q < need)) begin
         run_d = run_q + RUN_W'(1);
      end else begin
         run_d = run_q;
      end
   end

   assign qualified = enable && !clear && window && (run_d >= need);

   always_ff @(posedge clk) begin
      if (!rst_n) run_q <= '0;
      else        run_q <= run_d;
   end
endmodule

// File: rtl/lock_cfg_watch.sv
`timescale 1ns/1ps
module lock_cfg_watch #(
   parameter int QUAL_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode,
   input  logic [QUAL_W-1:0] qual_cnt,
   output logic              changed
);
   logic              mode_q;
   logic [QUAL_W-1:0] qual_q;

   assign changed = (mode != mode_q) || (qual_cnt != qual_q);

   // Settings are captured during reset so leaving reset is not a change.
   always_ff @(posedge clk) begin
      mode_q <= mode;
      qual_q <= qual_cnt;
   end

   logic unused_rst;
   assign unused_rst = rst_n;
endmodule

// File: rtl/pll_lock_qualifier.sv
`timescale 1ns/1ps
module pll_lock_qualifier
   import pll_lock_pkg::*;
#(
   parameter int QUAL_W   = 8,
   parameter int MIN_QUAL = 16,
   parameter int TMO_W    = 16,
   parameter int MIN_TMO  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pd_strobe,
   input  logic              in_window,
   input  logic              mode_freq,
   input  logic [QUAL_W-1:0] qual_cnt,
   input  logic [TMO_W-1:0]  ref_timeout,
   output logic              lock_o
);
   generate
      if (QUAL_W < 1 || QUAL_W > 16) begin : g_bad_qual_w
         $error("QUAL_W out of range");
      end
      if (MIN_QUAL < 1 || MIN_QUAL > (1 << QUAL_W)) begin : g_bad_min_qual
         $error("MIN_QUAL must lie within 1 .. 2**QUAL_W");
      end
      if (TMO_W < 2 || TMO_W > 24) begin : g_bad_tmo_w
         $error("TMO_W out of range");
      end
      if (MIN_TMO < 1 || MIN_TMO >= (1 << TMO_W)) begin : g_bad_min_tmo
         $error("MIN_TMO must be representable and nonzero");
      end
   endgenerate

   lock_mode_e mode;
   logic       cfg_changed;
   logic       ref_ok;
   logic       run_ok;
   logic       lock_d;
   logic       lock_q;

   assign mode = lock_mode_e'(mode_freq);

   lock_cfg_watch #(.QUAL_W(QUAL_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode_freq),
      .qual_cnt (qual_cnt),
      .changed  (cfg_changed)
   );

   lock_ref_watchdog #(.TMO_W(TMO_W), .MIN_TMO(MIN_TMO)) u_wdog (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (pd_strobe),
      .tmo_in (ref_timeout),
      .ref_ok (ref_ok)
   );

   lock_run_counter #(.QUAL_W(QUAL_W), .MIN_QUAL(MIN_QUAL)) u_run (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (mode == LK_FREQ),
      .clear     (cfg_changed),
      .window    (in_window),
      .strobe    (pd_strobe),
      .qual_cnt  (qual_cnt),
      .qualified (run_ok)
   );

   always_comb begin
      if (cfg_changed)          lock_d = 1'b0;
      else if (mode == LK_FREQ) lock_d = run_ok;
      else                      lock_d = in_window && ref_ok;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) lock_q <= 1'b0;
      else        lock_q <= lock_d;
   end

   assign lock_o = lock_q;
endmodule

// File: rtl/lock_qualifier_chk.sv
`timescale 1ns/1ps
module lock_qualifier_chk #(
   parameter int QUAL_W  = 8,
   parameter int TMO_W   = 16,
   parameter int MIN_TMO = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pd_strobe,
   input logic              in_window,
   input logic              mode_freq,
   input logic [QUAL_W-1:0] qual_cnt,
   input logic [TMO_W-1:0]  ref_timeout,
   input logic              lock_o
);
   localparam logic [TMO_W-1:0] FLOOR = TMO_W'(MIN_TMO);

   logic [TMO_W-1:0] idle_q;
   logic [TMO_W-1:0] limit;
   assign limit = (ref_timeout < FLOOR) ? FLOOR : ref_timeout;

   always_ff @(posedge clk) begin
      if (!rst_n || pd_strobe) idle_q <= '0;
      else if (idle_q != '1)   idle_q <= idle_q + TMO_W'(1);
   end

   // R1: phase tracking with steady settings locks on the next edge
   p_phase_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_freq && $stable(mode_freq) && $stable(qual_cnt) && in_window && pd_strobe)
      |=> lock_o);

   // R2: in frequency tracking, no strobe means no new lock
   p_freq_no_early_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_freq && !lock_o && !pd_strobe) |=> !lock_o);

   // R4: window loss drops the lock in any mode
   p_window_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !in_window |=> !lock_o);

   // R5: phase tracking withdraws the lock once the quiet run exceeds the limit
   p_ref_lost_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_freq && !pd_strobe && idle_q >= limit) |=> !lock_o);

   // R6: frequency tracking keeps a held lock without strobes
   p_freq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_freq && lock_o && in_window && !pd_strobe && $stable(mode_freq) && $stable(qual_cnt))
      |=> lock_o);

   // R8: a settings change clears the lock
   p_cfg_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(mode_freq) || !$stable(qual_cnt)) |=> !lock_o);
endmodule

bind pll_lock_qualifier lock_qualifier_chk #(
   .QUAL_W  (QUAL_W),
   .TMO_W   (TMO_W),
   .MIN_TMO (MIN_TMO)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pd_strobe   (pd_strobe),
   .in_window   (in_window),
   .mode_freq   (mode_freq),
   .qual_cnt    (qual_cnt),
   .ref_timeout (ref_timeout),
   .lock_o      (lock_o)
);

// File: tb/pll_lock_qualifier_tb.sv
`timescale 1ns/1ps
module pll_lock_qualifier_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pd_strobe = 1'b0;
   logic        in_window = 1'b0;
   logic        mode_freq = 1'b0;
   logic [7:0]  qual_cnt = 8'd19;
   logic [15:0] ref_timeout = 16'd5;
   logic        lock_o;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   pll_lock_qualifier u_dut (
      .clk(clk), .rst_n(rst_n), .pd_strobe(pd_strobe), .in_window(in_window),
      .mode_freq(mode_freq), .qual_cnt(qual_cnt), .ref_timeout(ref_timeout),
      .lock_o(lock_o)
   );

   task automatic tick(input int n);
      repeat (n) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic chk(input string req, input logic exp);
      n_chk++;
      if (lock_o !== exp) begin
         n_bad++;
         $display("FAIL %s: lock_o actual=%b expected=%b at %0t", req, lock_o, exp, $time);
      end
   endtask

   task automatic strobes(input int n);
      pd_strobe = 1'b1;
      tick(n);
      pd_strobe = 1'b0;
   endtask

   task automatic settle_cfg(input logic m, input logic [7:0] q);
      mode_freq = m; qual_cnt = q; in_window = 1'b0; pd_strobe = 1'b0;
      tick(2);
   endtask

   task automatic t_reset;
      in_window = 1'b1; pd_strobe = 1'b1;
      tick(3);
      chk("R7 reset state", 1'b0);
      rst_n = 1'b1;
      tick(1);
      chk("R1 first edge out of reset", 1'b1);
      pd_strobe = 1'b0;
   endtask

   task automatic t_phase;
      settle_cfg(1'b0, 8'd19);
      ref_timeout = 16'd5;
      in_window = 1'b1; strobes(1);
      chk("R1 immediate lock", 1'b1);
      in_window = 1'b0; tick(1);
      chk("R4 phase window loss", 1'b0);
      in_window = 1'b1; tick(1);
      chk("R1 relock without strobe", 1'b1);
   endtask

   task automatic t_watchdog;
      settle_cfg(1'b0, 8'd19);
      ref_timeout = 16'd5; in_window = 1'b1;
      strobes(1);
      tick(5);
      chk("R5 quiet clocks equal limit", 1'b1);
      tick(1);
      chk("R5 quiet clocks exceed limit", 1'b0);
      strobes(1);
      chk("R5 strobe revives", 1'b1);
      tick(5);
      strobes(1);
      chk("R5 strobe on expiry clock", 1'b1);
      tick(5);
      chk("R5 after coincident strobe", 1'b1);
      ref_timeout = 16'd0;
      strobes(1);
      tick(2);
      chk("R5 clamped limit reached", 1'b1);
      tick(1);
      chk("R5 clamped limit exceeded", 1'b0);
      ref_timeout = 16'd5;
   endtask

   task automatic t_freq;
      settle_cfg(1'b1, 8'd19);
      in_window = 1'b1;
      strobes(19);
      chk("R2 run one short", 1'b0);
      strobes(1);
      chk("R2 run complete", 1'b1);
      tick(100);
      chk("R6 lock held with reference stopped", 1'b1);
      in_window = 1'b0; tick(1);
      chk("R4 freq window loss", 1'b0);
      in_window = 1'b1;
      for (int i = 0; i < 19; i++) begin
         strobes(1);
         tick(1);
      end
      chk("R2 gapped run one short", 1'b0);
      strobes(1);
      chk("R2 gapped run complete", 1'b1);
      in_window = 1'b0; tick(1);
      in_window = 1'b1; strobes(10);
      in_window = 1'b0; strobes(1);
      chk("R4 strobe with window low", 1'b0);
      in_window = 1'b1; strobes(19);
      chk("R4 run restarted after loss", 1'b0);
      strobes(1);
      chk("R4 full run after loss", 1'b1);
   endtask

   task automatic t_clamp;
      settle_cfg(1'b1, 8'd3);
      in_window = 1'b1;
      strobes(15);
      chk("R3 low setting, 15 strobes", 1'b0);
      strobes(1);
      chk("R3 low setting, 16 strobes", 1'b1);
      settle_cfg(1'b1, 8'd255);
      in_window = 1'b1;
      strobes(255);
      chk("R3 top setting, 255 strobes", 1'b0);
      strobes(1);
      chk("R3 top setting, 256 strobes", 1'b1);
   endtask

   task automatic t_cfg;
      qual_cnt = 8'd254; tick(1);
      chk("R8 count change clears", 1'b0);
      strobes(1);
      chk("R8 run restarts", 1'b0);
      mode_freq = 1'b0; pd_strobe = 1'b1; tick(1);
      chk("R8 mode change clears", 1'b0);
      tick(1);
      pd_strobe = 1'b0;
      chk("R1 phase lock after mode change", 1'b1);
      rst_n = 1'b0; tick(1);
      chk("R7 synchronous reset while locked", 1'b0);
      rst_n = 1'b1;
   endtask

   initial begin
      t_reset();
      t_phase();
      t_watchdog();
      t_freq();
      t_clamp();
      t_cfg();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL all: watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule